// File: doc/BRIEF.md
# UART Interrupt Pending Controller

This block gathers the four interrupt causes of one serial channel into a sticky source register. It masks them and drives a single level-sensitive interrupt request. Receive, error, transmit and modem events arrive as one-cycle pulses and set their source bits. Software clears the bits through a small register port. Writing ones to either the source address or the pending address clears the selected source bits.

The block also watches the transmit FIFO occupancy. A 3-bit trigger field in a FIFO control word is scaled by a per-channel factor of 32, 8 or 2, chosen at build time. While the FIFO is enabled and the occupancy is at or below the scaled level, the transmit source bit is held set. The pending view is the source register with the masked bits removed. The interrupt line follows it with no extra register stage, so a mask write takes effect on the clock edge that captures it.

Top module: `uirq_ctrl`

## Requirements
- R1: Source bit positions are receive = bit 0, error = bit 1, transmit = bit 2, modem = bit 3. A one-cycle pulse on an event input sets its bit at the next clock edge, and the bit stays set until software clears it.
- R2: The value read at the pending address always equals the source register AND NOT the mask register.
- R3: `irq` is high exactly when some pending bit is set. A mask change is reflected on `irq` right after the edge that captures the write.
- R4: A write to the pending address (address 1) clears every source bit whose write-data bit is one, masked bits included. All other source bits are left unchanged.
- R5: A write to the source address (address 0) clears only the source bits whose write-data bit is one. Write-data bits above bit 3 are ignored, and the mask and FIFO control registers do not change.
- R6: The FIFO control register sits at address 2'd3 and reads back as written. Its bits 10:8 form the trigger field. The effective level is the field times 32 for CHAN_CLASS 0, times 8 for CHAN_CLASS 1 and times 2 for CHAN_CLASS 2. The other bits of the register do not affect the level.
- R7: While `fifo_en` is high and `tx_count` is less than or equal to the effective level, the transmit source bit is set on every edge. With `fifo_en` low, or with the count above the level, the threshold sets nothing.
- R8: If an event pulse and a write-one clear hit the same source bit in the same cycle, the bit ends up set.
- R9: While `rst_n` is low, `irq` is low and event pulses are not recorded. After reset, the source, mask and FIFO control registers read zero.
- R10: The mask register sits at address 2'd2 and reads back its 4-bit value zero-extended. A one in a mask bit removes that source from the pending view.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 source, 1 pending, 2 mask, 3 FIFO control |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| ev_rx | input | 1 | Receive event pulse |
| ev_err | input | 1 | Error event pulse |
| ev_tx | input | 1 | Transmit event pulse |
| ev_modem | input | 1 | Modem event pulse |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| fifo_en | input | 1 | FIFO mode enabled |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds two copies side by side on shared stimulus. One uses CHAN_CLASS 1 (×8 scale) and the other uses CHAN_CLASS 0 (×32 scale), both with an 8-bit count and 16-bit data. This makes the exact level boundaries reachable: 16 against 17 and 64 against 65 for a field of 2, and 56 and 224 for a field of 7. A single count value therefore sits above one channel's level and below the other's. The field-of-zero case tests the level-zero edge, and the bench also drives collisions between set and clear and clears of masked bits.

// File: rtl/uirq_pkg.sv
// Shared constants and types for the UART interrupt pending controller.
package uirq_pkg;
    localparam int SRC_N    = 4;
    localparam int BIT_RX   = 0;
    localparam int BIT_ERR  = 1;
    localparam int BIT_TX   = 2;
    localparam int BIT_MDM  = 3;
    localparam int TRIG_LSB = 8;
    localparam int TRIG_W   = 3;

    typedef enum logic [1:0] {
        A_SRC  = 2'd0,
        A_PEND = 2'd1,
        A_MASK = 2'd2,
        A_FCTL = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/uirq_src_reg.sv
// Sticky source register: one flop per source, set by an event, cleared
// by write-one. Assumes set and clr are single-cycle qualified vectors;
// set takes priority over clr on the same bit.
module uirq_src_reg #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-bit update: reset, then set-over-clear priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/uirq_cfg.sv
// Holds the mask and FIFO control words written over the register port.
// Assumes write strobes are already decoded by address.
module uirq_cfg #(
    parameter int DW = 16,
    parameter int N  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_mask,
    input  logic          wr_fctl,
    input  logic [DW-1:0] wdata,
    output logic [N-1:0]  mask_q,
    output logic [DW-1:0] fctl_q
);
    // Mask register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_mask)
            mask_q <= wdata[N-1:0];
    end

    // FIFO control register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fctl_q <= '0;
        else if (wr_fctl)
            fctl_q <= wdata;
    end
endmodule

// File: rtl/uirq_tx_level.sv
// Compares the transmit FIFO count with the scaled trigger level.
// CHAN_CLASS selects the scale: 0 -> x32, 1 -> x8, other -> x2.
// Purely combinational; assumes count is a stable registered value.
module uirq_tx_level
    import uirq_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int CHAN_CLASS = 0
) (
    input  logic [TRIG_W-1:0] trig,
    input  logic [CNT_W-1:0]  count,
    input  logic              fifo_en,
    output logic              hit
);
    localparam int LVL_W = TRIG_W + 5;
    localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    logic [CMP_W-1:0] lvl;

    if (CHAN_CLASS == 0) begin : g_x32
        assign lvl = CMP_W'({trig, 5'd0});
    end else if (CHAN_CLASS == 1) begin : g_x8
        assign lvl = CMP_W'({trig, 3'd0});
    end else begin : g_x2
        assign lvl = CMP_W'({trig, 1'b0});
    end

    // Threshold hit while FIFO mode is on and occupancy is at or under level.
    always_comb hit = fifo_en && (CMP_W'(count) <= lvl);
endmodule

// File: rtl/uirq_ctrl.sv
// Top of the UART interrupt pending controller. Decodes register writes,
// merges event pulses and the transmit threshold into the source register,
// derives the pending view and the level interrupt. Assumes DW >= 11 so
// the trigger field fits in the FIFO control word.
module uirq_ctrl
    import uirq_pkg::*;
#(
    parameter int DW         = 16,
    parameter int CNT_W      = 8,
    parameter int CHAN_CLASS = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             ev_rx,
    input  logic             ev_err,
    input  logic             ev_tx,
    input  logic             ev_modem,
    input  logic [CNT_W-1:0] tx_count,
    input  logic             fifo_en,
    output logic             irq
);
    logic [SRC_N-1:0] src_q;
    logic [SRC_N-1:0] mask_q;
    logic [SRC_N-1:0] pend;
    logic [SRC_N-1:0] set_v;
    logic [SRC_N-1:0] clr_v;
    logic [DW-1:0]    fctl_q;
    logic             tx_hit;
    logic             wr_mask;
    logic             wr_fctl;

    // Write strobe decode for the configuration registers.
    always_comb begin
        wr_mask = reg_wr && (reg_addr == A_MASK);
        wr_fctl = reg_wr && (reg_addr == A_FCTL);
    end

    // Set vector from the event pulses and the transmit threshold.
    always_comb begin
        set_v          = '0;
        set_v[BIT_RX]  = ev_rx;
        set_v[BIT_ERR] = ev_err;
        set_v[BIT_TX]  = ev_tx | tx_hit;
        set_v[BIT_MDM] = ev_modem;
    end

    // Write-one clear from either the source or the pending address.
    always_comb begin
        if (reg_wr && (reg_addr == A_SRC || reg_addr == A_PEND))
            clr_v = reg_wdata[SRC_N-1:0];
        else
            clr_v = '0;
    end

    uirq_src_reg #(.N(SRC_N)) u_src (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (clr_v),
        .q     (src_q)
    );

    uirq_cfg #(.DW(DW), .N(SRC_N)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_fctl (wr_fctl),
        .wdata   (reg_wdata),
        .mask_q  (mask_q),
        .fctl_q  (fctl_q)
    );

    uirq_tx_level #(.CNT_W(CNT_W), .CHAN_CLASS(CHAN_CLASS)) u_lvl (
        .trig    (fctl_q[TRIG_LSB +: TRIG_W]),
        .count   (tx_count),
        .fifo_en (fifo_en),
        .hit     (tx_hit)
    );

    // Pending view and interrupt line, held low during reset.
    always_comb begin
        pend = src_q & ~mask_q;
        irq  = rst_n & (|pend);
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr)
            A_SRC:   reg_rdata = DW'(src_q);
            A_PEND:  reg_rdata = DW'(pend);
            A_MASK:  reg_rdata = DW'(mask_q);
            default: reg_rdata = fctl_q;
        endcase
    end
endmodule

// File: rtl/uirq_ctrl_chk.sv
// Property checker for uirq_ctrl, attached by bind below. Observes the
// register port, the event pulses and the internal source/mask state.
module uirq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [3:0] wbits,
    input logic       ev_rx,
    input logic       ev_err,
    input logic       ev_modem,
    input logic       tx_hit,
    input logic [3:0] src_q,
    input logic [3:0] mask_q,
    input logic       irq
);
    // R3: interrupt follows the unmasked source bits.
    assert_irq_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(src_q & ~mask_q)));

    // R1: receive pulse sets bit 0.
    assert_rx_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx |=> src_q[0]);

    // R8: error pulse wins over a same-cycle pending clear.
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_err && reg_wr && reg_addr == 2'd1 && wbits[1]) |=> src_q[1]);

    // R4: pending write clears the modem source bit.
    assert_pend_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && wbits[3] && !ev_modem) |=> !src_q[3]);

    // R5: source write clears the receive source bit.
    assert_src_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && wbits[0] && !ev_rx) |=> !src_q[0]);

    // R7: a threshold hit sets the transmit bit.
    assert_tx_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hit |=> src_q[2]);

    // R10: mask write is captured.
    assert_mask_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=> (mask_q == $past(wbits)));

    // R9: reset clears the state.
    assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> (src_q == 4'd0 && mask_q == 4'd0));

    // R9: interrupt is low while reset is asserted.
    always @(negedge clk) begin
        if (rst_n === 1'b0)
            assert_irq_rst_R9: assert (irq == 1'b0);
    end
endmodule

bind uirq_ctrl uirq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wbits    (reg_wdata[3:0]),
    .ev_rx    (ev_rx),
    .ev_err   (ev_err),
    .ev_modem (ev_modem),
    .tx_hit   (tx_hit),
    .src_q    (src_q),
    .mask_q   (mask_q),
    .irq      (irq)
);

// File: tb/uirq_ctrl_tb.sv
`timescale 1ns/1ps
module uirq_ctrl_tb;
    localparam logic [1:0] AS = 2'd0, AP = 2'd1, AM = 2'd2, AF = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic        ev_rx = 0, ev_err = 0, ev_tx = 0, ev_modem = 0;
    logic [7:0]  tx_count = '0;
    logic        fifo_en = 1'b0;
    logic [15:0] rd_a, rd_b;
    logic        irq_a, irq_b;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    uirq_ctrl #(.DW(16), .CNT_W(8), .CHAN_CLASS(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_a), .ev_rx(ev_rx), .ev_err(ev_err),
        .ev_tx(ev_tx), .ev_modem(ev_modem), .tx_count(tx_count),
        .fifo_en(fifo_en), .irq(irq_a));

    uirq_ctrl #(.DW(16), .CNT_W(8), .CHAN_CLASS(0)) u_dut_w (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(rd_b), .ev_rx(ev_rx), .ev_err(ev_err),
        .ev_tx(ev_tx), .ev_modem(ev_modem), .tx_count(tx_count),
        .fifo_en(fifo_en), .irq(irq_b));

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] va, output logic [15:0] vb);
        reg_addr = a;
        #1;
        va = rd_a;
        vb = rd_b;
    endtask

    task automatic pulse(input logic [3:0] ev);
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = ev;
        @(negedge clk);
        {ev_modem, ev_tx, ev_err, ev_rx} = 4'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // R9: reset state and no capture during reset.
    task automatic t_reset();
        logic [15:0] a, b;
        rst_n = 1'b0;
        ev_rx = 1'b1; ev_modem = 1'b1;
        repeat (3) @(negedge clk);
        check("R9", "irq during reset", {15'd0, irq_a}, 16'd0);
        ev_rx = 1'b0; ev_modem = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), a, b);
            check("R9", "register after reset", a, 16'd0);
        end
        check("R9", "irq after reset", {15'd0, irq_a}, 16'd0);
    endtask

    // R1 R2 R3 R4: each event alone, then cleared through the pending address.
    task automatic t_events();
        logic [15:0] a, b;
        for (int i = 0; i < 4; i++) begin
            pulse(4'(1 << i));
            rd(AS, a, b);
            check("R1", "source bit position", a, 16'(1 << i));
            rd(AP, a, b);
            check("R2", "pending equals source", a, 16'(1 << i));
            check("R3", "irq raised", {15'd0, irq_a}, 16'd1);
            wr(AP, 16'(1 << i));
            rd(AS, a, b);
            check("R4", "pending write clears source", a, 16'd0);
            check("R3", "irq dropped", {15'd0, irq_a}, 16'd0);
        end
    endtask

    // R2 R3 R4 R5 R10: masking and clearing of masked bits.
    task automatic t_mask();
        logic [15:0] a, b;
        pulse(4'b1001);
        wr(AM, 16'h0001);
        rd(AM, a, b);
        check("R10", "mask readback", a, 16'h0001);
        rd(AP, a, b);
        check("R2", "pending with rx masked", a, 16'h0008);
        check("R3", "irq with one unmasked", {15'd0, irq_a}, 16'd1);
        wr(AM, 16'h0009);
        rd(AP, a, b);
        check("R10", "fully masked pending", a, 16'h0000);
        check("R3", "irq off after mask write", {15'd0, irq_a}, 16'd0);
        rd(AS, a, b);
        check("R2", "source kept under mask", a, 16'h0009);
        wr(AP, 16'h0008);
        rd(AS, a, b);
        check("R4", "masked bit cleared by pending write", a, 16'h0001);
        wr(AM, 16'h0000);
        check("R3", "irq back after unmask", {15'd0, irq_a}, 16'd1);
        wr(AS, 16'h0001);
        rd(AS, a, b);
        check("R5", "source write clears", a, 16'h0000);
    endtask

    // R5: source write clears only selected bits, nothing else moves.
    task automatic t_src_clear();
        logic [15:0] a, b;
        wr(AF, 16'h0005);
        pulse(4'b0110);
        wr(AS, 16'hFFF2);
        rd(AS, a, b);
        check("R5", "only bit1 cleared", a, 16'h0004);
        rd(AM, a, b);
        check("R5", "mask untouched", a, 16'h0000);
        rd(AF, a, b);
        check("R5", "fifo control untouched", a, 16'h0005);
        wr(AS, 16'h0004);
        wr(AF, 16'h0000);
    endtask

    // R8: set and clear on the same bit in one cycle.
    task automatic t_collide();
        logic [15:0] a, b;
        @(negedge clk);
        ev_err = 1'b1; reg_wr = 1'b1; reg_addr = AP; reg_wdata = 16'h0002;
        @(negedge clk);
        ev_err = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(AS, a, b);
        check("R8", "set wins over clear", a, 16'h0002);
        wr(AS, 16'h0002);
    endtask

    task automatic tx_try(input logic [7:0] cnt, input logic [15:0] ea,
                          input logic [15:0] eb, input string what);
        logic [15:0] a, b;
        @(negedge clk);
        fifo_en = 1'b0;
        wr(AS, 16'h0004);
        tx_count = cnt;
        fifo_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(AS, a, b);
        check("R7", {what, " x8 channel"}, a, ea);
        check("R7", {what, " x32 channel"}, b, eb);
        check("R3", {what, " irq x32"}, {15'd0, irq_b}, {15'd0, eb[2]});
    endtask

    // R6 R7: trigger field scaling and threshold boundaries.
    task automatic t_thresh();
        logic [15:0] a, b;
        wr(AF, 16'h0200);
        rd(AF, a, b);
        check("R6", "fifo control readback", a, 16'h0200);
        tx_try(8'd17, 16'h0000, 16'h0004, "R6 count 17 field 2");
        tx_try(8'd16, 16'h0004, 16'h0004, "count 16 field 2");
        tx_try(8'd65, 16'h0000, 16'h0000, "count 65 field 2");
        tx_try(8'd64, 16'h0000, 16'h0004, "count 64 field 2");
        wr(AF, 16'h0700);
        tx_try(8'd56, 16'h0004, 16'h0004, "count 56 field 7");
        tx_try(8'd57, 16'h0000, 16'h0004, "count 57 field 7");
        tx_try(8'd224, 16'h0000, 16'h0004, "count 224 field 7");
        tx_try(8'd225, 16'h0000, 16'h0000, "count 225 field 7");
        wr(AF, 16'h00FF);
        tx_try(8'd0, 16'h0004, 16'h0004, "R6 other bits ignored count 0");
        tx_try(8'd1, 16'h0000, 16'h0000, "R6 other bits ignored count 1");
        @(negedge clk);
        fifo_en = 1'b0;
        tx_count = 8'd0;
        wr(AS, 16'h0004);
        @(negedge clk);
        rd(AS, a, b);
        check("R7", "fifo disabled sets nothing", a, 16'h0000);
        check("R7", "fifo disabled sets nothing wide", b, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_events();
        t_mask();
        t_src_clear();
        t_collide();
        t_thresh();
        done = 1;
        summary();
        $finish;
    end
endmodule